// File: doc/BRIEF.md
# Multi-Mode Configurable I/O Port

This block is a parallel I/O port of parameterised width (eight pins by default). It sits in a microcontroller's register space behind a small strobe-based register bus. The CPU writes an output-data register, a direction register and an optional per-pin mode register. Each pin then resolves on its own to one of three output sources: the CPU's output-data bit, an output from an external logic array, or one byte of an address latched from a multiplexed address/data bus. An external per-pin product-term enable takes part in deciding whether the pin drives.

The pin levels reach the CPU through a two-flop synchronizer and the input-data register. The address byte is captured when the address-latch strobe falls. A parameter chooses whether the low or the high address byte reaches the pins. A second parameter removes the mode register, which leaves every pin a plain CPU-controlled pin. Pad drivers and the logic array sit outside this block.

Top module: `cfg_io_port`

## Requirements
- R1: Synchronous active-high reset clears the output-data, direction and mode registers to 0. Every pin is then in CPU mode as an input, and `pin_oe` is 0 wherever `pt_oe` is 0.
- R2: Register offsets on `bus_addr`: 0 is input data (read only), 1 is output data, 2 is direction, 3 is mode. A write takes effect on the clock edge that samples `bus_we`. A read loads `bus_rdata` on the edge that samples `bus_re`. Registers 1 to 3 read back the last value written.
- R3: A pin whose mode bit is 0 is in CPU mode. `pin_out` carries its output-data bit and `pin_oe` equals its direction bit OR its `pt_oe` bit, where direction 1 means output.
- R4: Reading offset 0 returns `pin_in` through two flops. A value applied before a clock edge is not yet visible in a read sampled at that edge, and it is visible in a read issued two edges later.
- R5: A pin whose mode bit and direction bit are both 1 is in address mode. It drives (`pin_oe`=1) the matching bit of the latched address byte.
- R6: A pin whose mode bit is 1 and direction bit is 0 is in logic-array mode. `pin_out` carries its `pld_out` bit and `pin_oe` follows its `pt_oe` bit, so the pin floats while `pt_oe` is 0.
- R7: `ad_bus` is captured on the first clock edge at which `ale` is 0 after having been 1. The captured value is held unchanged until the next such falling transition, whatever `ad_bus` does meanwhile.
- R8: With `HI_BYTE`=0 address mode presents bits 7..0 of the captured address; with `HI_BYTE`=1 it presents bits 15..8.
- R9: With `HAS_CTRL`=0, writes to offset 3 are ignored and the offset reads 0. Every pin stays in CPU mode, even when its direction bit is 1.
- R10: Each pin resolves its mode independently, so one port may mix CPU, address and logic-array pins at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_re | input | 1 | Register read strobe |
| bus_addr | input | 2 | Register offset |
| bus_wdata | input | WIDTH | Write data |
| bus_rdata | output | WIDTH | Read data, loaded one edge after the strobe |
| ale | input | 1 | Address-latch strobe, captures on its falling transition |
| ad_bus | input | ADDR_W | Multiplexed address/data bus |
| pt_oe | input | WIDTH | Per-pin product-term output enable |
| pld_out | input | WIDTH | Per-pin logic-array output value |
| pin_in | input | WIDTH | Pin levels from the pads |
| pin_out | output | WIDTH | Per-pin output value |
| pin_oe | output | WIDTH | Per-pin output enable |

## Verification
The bench walks mode/direction/enable combinations, including a mixed byte with all three modes present. A design with a wrong priority between the product-term enable and the direction bit would drive logic-array pins that should float, or leave address pins floating. It checks that the address holds while `ad_bus` changes after the strobe falls; a level-sensitive latch would follow the bus. It reads input data one edge too early, so a single-flop or combinational path shows up. Two extra instances cover the high-byte selection and a port built without the mode register, where a write that leaked into that register would switch pins to address mode.

// File: rtl/cfg_io_port_pkg.sv
package cfg_io_port_pkg;

    localparam int REG_AW = 2;

    typedef enum logic [REG_AW-1:0] {
        RA_PIN  = 2'd0,
        RA_DOUT = 2'd1,
        RA_DIR  = 2'd2,
        RA_CTRL = 2'd3
    } reg_sel_e;

    typedef enum logic [1:0] {
        PM_CPU  = 2'd0,
        PM_ADDR = 2'd1,
        PM_PLD  = 2'd2
    } pin_mode_e;

    typedef struct packed {
        logic out;
        logic oe;
    } pin_drv_t;

    function automatic pin_mode_e decode_mode(logic mode_bit, logic dir_bit);
        if (!mode_bit)    return PM_CPU;
        else if (dir_bit) return PM_ADDR;
        else              return PM_PLD;
    endfunction

endpackage

// File: rtl/cfg_io_port_regs.sv
module cfg_io_port_regs
    import cfg_io_port_pkg::*;
#(
    parameter int WIDTH    = 8,
    parameter bit HAS_CTRL = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_we,
    input  logic              bus_re,
    input  logic [REG_AW-1:0] bus_addr,
    input  logic [WIDTH-1:0]  bus_wdata,
    input  logic [WIDTH-1:0]  pin_sync,
    output logic [WIDTH-1:0]  dout_q,
    output logic [WIDTH-1:0]  dir_q,
    output logic [WIDTH-1:0]  ctrl_q,
    output logic [WIDTH-1:0]  bus_rdata
);

    reg_sel_e sel;
    assign sel = reg_sel_e'(bus_addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            dout_q <= '0;
            dir_q  <= '0;
        end else if (bus_we) begin
            if (sel == RA_DOUT) dout_q <= bus_wdata;
            if (sel == RA_DIR)  dir_q  <= bus_wdata;
        end
    end

    generate
        if (HAS_CTRL) begin : g_ctrl
            always_ff @(posedge clk) begin
                if (rst)                          ctrl_q <= '0;
                else if (bus_we && sel == RA_CTRL) ctrl_q <= bus_wdata;
            end
        end else begin : g_no_ctrl
            assign ctrl_q = '0;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rdata <= '0;
        end else if (bus_re) begin
            unique case (sel)
                RA_PIN:  bus_rdata <= pin_sync;
                RA_DOUT: bus_rdata <= dout_q;
                RA_DIR:  bus_rdata <= dir_q;
                RA_CTRL: bus_rdata <= ctrl_q;
                default: bus_rdata <= '0;
            endcase
        end
    end

    a_r1_regs_cleared: assert property (@(posedge clk)
        $past(rst) |-> (dout_q == '0 && dir_q == '0 && ctrl_q == '0));

    a_r2_dout_write: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == RA_DOUT) |=> dout_q == $past(bus_wdata));

    a_r2_dir_write: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == RA_DIR) |=> dir_q == $past(bus_wdata));

endmodule

// File: rtl/cfg_io_port_sync.sv
module cfg_io_port_sync #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] meta_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            q      <= '0;
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end

    a_r4_two_stage: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |=> q == $past(d, 2));

endmodule

// File: rtl/cfg_io_port_addr_latch.sv
module cfg_io_port_addr_latch #(
    parameter int WIDTH   = 8,
    parameter int ADDR_W  = 16,
    parameter bit HI_BYTE = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ale,
    input  logic [ADDR_W-1:0] ad_bus,
    output logic [WIDTH-1:0]  addr_byte
);

    logic              ale_q;
    logic              ale_fall;
    logic [ADDR_W-1:0] addr_q;

    assign ale_fall = ale_q && !ale;

    always_ff @(posedge clk) begin
        if (rst) begin
            ale_q  <= 1'b0;
            addr_q <= '0;
        end else begin
            ale_q <= ale;
            if (ale_fall) addr_q <= ad_bus;
        end
    end

    generate
        if (HI_BYTE) begin : g_hi
            assign addr_byte = addr_q[2*WIDTH-1:WIDTH];
        end else begin : g_lo
            assign addr_byte = addr_q[WIDTH-1:0];
        end
    endgenerate

    a_r7_capture: assert property (@(posedge clk) disable iff (rst)
        ale_fall |=> addr_q == $past(ad_bus));

    a_r7_hold: assert property (@(posedge clk) disable iff (rst)
        !ale_fall |=> $stable(addr_q));

endmodule

// File: rtl/cfg_io_port_pin_mux.sv
module cfg_io_port_pin_mux
    import cfg_io_port_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] dout_q,
    input  logic [WIDTH-1:0] dir_q,
    input  logic [WIDTH-1:0] ctrl_q,
    input  logic [WIDTH-1:0] addr_byte,
    input  logic [WIDTH-1:0] pt_oe,
    input  logic [WIDTH-1:0] pld_out,
    output logic [WIDTH-1:0] pin_out,
    output logic [WIDTH-1:0] pin_oe
);

    generate
        for (genvar i = 0; i < WIDTH; i++) begin : g_pin
            pin_drv_t drv;
            always_comb begin
                unique case (decode_mode(ctrl_q[i], dir_q[i]))
                    PM_ADDR: drv = '{out: addr_byte[i], oe: 1'b1};
                    PM_PLD:  drv = '{out: pld_out[i],   oe: pt_oe[i]};
                    default: drv = '{out: dout_q[i],    oe: dir_q[i] | pt_oe[i]};
                endcase
            end
            assign pin_out[i] = drv.out;
            assign pin_oe[i]  = drv.oe;
        end
    endgenerate

endmodule

// File: rtl/cfg_io_port.sv
module cfg_io_port
    import cfg_io_port_pkg::*;
#(
    parameter int WIDTH    = 8,
    parameter int ADDR_W   = 2 * WIDTH,
    parameter bit HAS_CTRL = 1'b1,
    parameter bit HI_BYTE  = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_we,
    input  logic              bus_re,
    input  logic [1:0]        bus_addr,
    input  logic [WIDTH-1:0]  bus_wdata,
    output logic [WIDTH-1:0]  bus_rdata,
    input  logic              ale,
    input  logic [ADDR_W-1:0] ad_bus,
    input  logic [WIDTH-1:0]  pt_oe,
    input  logic [WIDTH-1:0]  pld_out,
    input  logic [WIDTH-1:0]  pin_in,
    output logic [WIDTH-1:0]  pin_out,
    output logic [WIDTH-1:0]  pin_oe
);

    logic [WIDTH-1:0] pin_sync;
    logic [WIDTH-1:0] dout_q;
    logic [WIDTH-1:0] dir_q;
    logic [WIDTH-1:0] ctrl_q;
    logic [WIDTH-1:0] addr_byte;

    cfg_io_port_sync #(.WIDTH(WIDTH)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pin_in),
        .q   (pin_sync)
    );

    cfg_io_port_regs #(.WIDTH(WIDTH), .HAS_CTRL(HAS_CTRL)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_we    (bus_we),
        .bus_re    (bus_re),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .pin_sync  (pin_sync),
        .dout_q    (dout_q),
        .dir_q     (dir_q),
        .ctrl_q    (ctrl_q),
        .bus_rdata (bus_rdata)
    );

    cfg_io_port_addr_latch #(.WIDTH(WIDTH), .ADDR_W(ADDR_W), .HI_BYTE(HI_BYTE)) u_latch (
        .clk       (clk),
        .rst       (rst),
        .ale       (ale),
        .ad_bus    (ad_bus),
        .addr_byte (addr_byte)
    );

    cfg_io_port_pin_mux #(.WIDTH(WIDTH)) u_mux (
        .dout_q    (dout_q),
        .dir_q     (dir_q),
        .ctrl_q    (ctrl_q),
        .addr_byte (addr_byte),
        .pt_oe     (pt_oe),
        .pld_out   (pld_out),
        .pin_out   (pin_out),
        .pin_oe    (pin_oe)
    );

    a_r5_addr_pins_drive: assert property (@(posedge clk) disable iff (rst)
        ((ctrl_q & dir_q) & ~pin_oe) == '0);

    a_r6_pld_floats: assert property (@(posedge clk) disable iff (rst)
        ((ctrl_q & ~dir_q & ~pt_oe) & pin_oe) == '0);

    a_r3_cpu_input_floats: assert property (@(posedge clk) disable iff (rst)
        ((~ctrl_q & ~dir_q & ~pt_oe) & pin_oe) == '0);

    a_r3_cpu_data: assert property (@(posedge clk) disable iff (rst)
        ((~ctrl_q) & (pin_out ^ dout_q)) == '0);

endmodule

// File: tb/test_cfg_io_port.sv
module test_cfg_io_port;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_we = 1'b0;
    logic        bus_re = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [7:0]  bus_wdata = 8'h00;
    logic        ale = 1'b0;
    logic [15:0] ad_bus = 16'h0000;
    logic [7:0]  pt_oe = 8'h00;
    logic [7:0]  pld_out = 8'h00;
    logic [7:0]  pin_in = 8'h00;

    logic [7:0] rd_lo, out_lo, oe_lo;
    logic [7:0] rd_hi, out_hi, oe_hi;
    logic [7:0] rd_nc, out_nc, oe_nc;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    cfg_io_port i_cfg_io_port (
        .clk(clk), .rst(rst), .bus_we(bus_we), .bus_re(bus_re), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(rd_lo), .ale(ale), .ad_bus(ad_bus),
        .pt_oe(pt_oe), .pld_out(pld_out), .pin_in(pin_in), .pin_out(out_lo), .pin_oe(oe_lo)
    );

    cfg_io_port #(.HI_BYTE(1'b1)) i_cfg_io_port_hi (
        .clk(clk), .rst(rst), .bus_we(bus_we), .bus_re(bus_re), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(rd_hi), .ale(ale), .ad_bus(ad_bus),
        .pt_oe(pt_oe), .pld_out(pld_out), .pin_in(pin_in), .pin_out(out_hi), .pin_oe(oe_hi)
    );

    cfg_io_port #(.HAS_CTRL(1'b0)) i_cfg_io_port_nc (
        .clk(clk), .rst(rst), .bus_we(bus_we), .bus_re(bus_re), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(rd_nc), .ale(ale), .ad_bus(ad_bus),
        .pt_oe(pt_oe), .pld_out(pld_out), .pin_in(pin_in), .pin_out(out_nc), .pin_oe(oe_nc)
    );

    typedef struct packed {
        logic [7:0] ctrl;
        logic [7:0] dir;
        logic [7:0] dout;
        logic [7:0] pt;
        logic [7:0] pld;
        logic [7:0] eout;
        logic [7:0] eoe;
    } vec_t;

    // latched address is 16'hA55A throughout the table
    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{ctrl:8'h00, dir:8'hFF, dout:8'h3C, pt:8'h00, pld:8'hFF, eout:8'h3C, eoe:8'hFF}, // R3 out
        '{ctrl:8'h00, dir:8'h00, dout:8'h3C, pt:8'h0F, pld:8'hFF, eout:8'h3C, eoe:8'h0F}, // R3 pt
        '{ctrl:8'hFF, dir:8'hFF, dout:8'h33, pt:8'h00, pld:8'h00, eout:8'h5A, eoe:8'hFF}, // R5
        '{ctrl:8'hFF, dir:8'h00, dout:8'h00, pt:8'hF0, pld:8'h96, eout:8'h96, eoe:8'hF0}, // R6
        '{ctrl:8'hFF, dir:8'h00, dout:8'h00, pt:8'h00, pld:8'h96, eout:8'h96, eoe:8'h00}, // R6 float
        '{ctrl:8'hF0, dir:8'hCC, dout:8'hAA, pt:8'h11, pld:8'h0F, eout:8'h4A, eoe:8'hDD}  // R10
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a);
        @(negedge clk);
        bus_re = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_re = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        check("R1 oe", oe_lo, 8'h00);
        rd(2'd1); check("R1 dout", rd_lo, 8'h00);
        rd(2'd2); check("R1 dir", rd_lo, 8'h00);
        rd(2'd3); check("R1 ctrl", rd_lo, 8'h00);

        // R7: capture on ale falling, then hold while bus moves
        @(negedge clk); ale = 1'b1; ad_bus = 16'hA55A;
        @(negedge clk); ale = 1'b0;
        @(negedge clk); ad_bus = 16'h1234;
        wr(2'd2, 8'hFF); wr(2'd3, 8'hFF);
        check("R7 hold", out_lo, 8'h5A);

        // main table walk
        for (int i = 0; i < NV; i++) begin
            wr(2'd3, VECS[i].ctrl);
            wr(2'd2, VECS[i].dir);
            wr(2'd1, VECS[i].dout);
            pt_oe = VECS[i].pt; pld_out = VECS[i].pld;
            @(negedge clk);
            check($sformatf("R3/R5/R6/R10 out v%0d", i), out_lo, VECS[i].eout);
            check($sformatf("R3/R5/R6/R10 oe v%0d", i), oe_lo, VECS[i].eoe);
            if (i == 2) begin
                check("R8 high byte", out_hi, 8'hA5);
                check("R9 no-ctrl out", out_nc, 8'h33);
                check("R9 no-ctrl oe", oe_nc, 8'hFF);
                rd(2'd3);
                check("R9 ctrl reads 0", rd_nc, 8'h00);
                check("R2 ctrl readback", rd_lo, 8'hFF);
            end
        end

        // R2: readback of direction
        wr(2'd2, 8'h5C);
        rd(2'd2); check("R2 dir readback", rd_lo, 8'h5C);
        rd(2'd1); check("R2 dout readback", rd_lo, 8'hAA);

        // R4: synchronizer latency
        @(negedge clk);
        pin_in = 8'hC3; bus_re = 1'b1; bus_addr = 2'd0;
        @(negedge clk); bus_re = 1'b0;
        check("R4 not yet visible", rd_lo, 8'h00);
        rd(2'd0); check("R4 visible", rd_lo, 8'hC3);

        // R7: second falling edge replaces the address
        wr(2'd3, 8'hFF); wr(2'd2, 8'hFF);
        @(negedge clk); ale = 1'b1; ad_bus = 16'h7E81;
        @(negedge clk); ale = 1'b0;
        @(negedge clk);
        check("R7 recapture", out_lo, 8'h81);
        check("R8 recapture high", out_hi, 8'h7E);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(4 * 100000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule